// File: doc/BRIEF.md
# Vertical Countdown Divider with Adaptive Sync Windows

This block produces the vertical drive pulse of a video timing chain. It counts half-line ticks since the last vertical retrace. It compares the arrival of the separated vertical sync against a window that depends on how well the incoming signal is locked. There are three operating modes. In search mode a wide window accepts almost any field length. In narrow mode the window is a few half-lines around the nominal field length, and the block coasts through missing syncs. In norm mode the divider runs at exactly 625 half-lines (50 Hz) or 525 half-lines (60 Hz), and sync only confirms the lock.

The block moves between modes by counting consecutive hits and misses, with hysteresis in both directions. Two control inputs override the automatic behaviour. One holds the divider in search mode, so that it relocks quickly after a channel change. The other pins it to a fixed 60 Hz norm.

The outputs are a one-cycle retrace pulse, the current mode and the detected field standard.

Top module: `vcount_div`

## Requirements
- R1: After reset, `mode` is 0 (search), `is_60` is 0 and `vpulse` is low. The mode codes are 0 = search, 1 = narrow, 2 = norm, and code 3 never appears.
- R2: Each cycle with `hl_tick` high is one half-line, and `vsync_in` is only considered in such cycles. Half-line positions are numbered from 1 after each retrace. In search mode, a sync at positions 488 to 722 causes a retrace. A sync outside that range is ignored. With no sync, the retrace happens at position 722. `vpulse` is high for exactly the one cycle after the tick that retraces.
- R3: In search mode, 16 consecutive syncs inside a standard band (622 to 628 for 50 Hz, 522 to 528 for 60 Hz) switch the mode to narrow, and `is_60` follows the band hit. Any search retrace without such a sync restarts the streak.
- R4: In narrow mode, a sync within nominal ±3 half-lines causes a retrace. With no such sync, a flywheel retrace happens at nominal + 3. A sync earlier than the window is ignored.
- R5: In narrow mode, 6 consecutive missed fields return the mode to search. Any hit clears the miss count.
- R6: In narrow mode, 15 consecutive syncs exactly at the nominal position (625 or 525) switch the mode to norm. A sync that is in the window but off nominal restarts this streak.
- R7: In norm mode, the retrace always happens at the nominal position, whether or not a sync arrives.
- R8: In norm mode, 3 consecutive fields without a sync at the nominal position drop the mode to narrow. A hit clears the miss count.
- R9: After dropping from norm to narrow, 3 consecutive misses with no hit in between return the mode to search.
- R10: While `force_search` is high, the mode is search from the next cycle on, and all streaks are cleared. This input takes precedence over `force_60`.
- R11: While `force_60` is high and `force_search` is low, the mode is norm with `is_60` = 1 from the next cycle on, and the field length is 525 half-lines.
- R12: The internal half-line counter never reaches 722. Two retrace pulses are never adjacent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hl_tick | input | 1 | One-cycle pulse per half-line |
| vsync_in | input | 1 | Separated vertical sync, sampled with `hl_tick` |
| force_search | input | 1 | Hold the divider in search mode |
| force_60 | input | 1 | Pin the divider to 60 Hz norm mode |
| vpulse | output | 1 | Vertical retrace pulse, one cycle wide |
| mode | output | 2 | 0 search, 1 narrow, 2 norm |
| is_60 | output | 1 | Detected or forced field standard is 60 Hz |

## Verification
The hardest state to reach is narrow mode entered by falling back from norm, where the miss limit is 3 instead of 6. Reaching it takes 31 consecutive well-placed syncs, followed by three norm fields with no sync. The bench keeps its own half-line count, restarted at every observed retrace pulse. It places each sync at an exact position, so it can walk the divider through the search, narrow, norm, narrow and search sequence in one run. It then repeats the climb at 60 Hz to check the ordinary 6-miss limit. Stray syncs are placed between ticks and outside the windows, and the field length that follows shows that they had no effect.

// File: rtl/vcount_pkg.sv
package vcount_pkg;

  typedef enum logic [1:0] {
    VC_SEARCH = 2'd0,
    VC_NARROW = 2'd1,
    VC_NORM   = 2'd2
  } vc_mode_e;

  // Position lies within center +/- tol (inclusive).
  function automatic logic in_band(input int unsigned pos,
                                   input int unsigned center,
                                   input int unsigned tol);
    return (pos + tol >= center) && (pos <= center + tol);
  endfunction

  // Nominal field length in half-lines for the selected standard.
  function automatic int unsigned field_len(input logic sel60,
                                            input int unsigned n50,
                                            input int unsigned n60);
    return sel60 ? n60 : n50;
  endfunction

endpackage

// File: rtl/vc_halfline_ctr.sv
module vc_halfline_ctr #(
  parameter int unsigned HL_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            retrace,
  output logic [HL_W-1:0] cnt,
  output logic [HL_W-1:0] pos,
  output logic            pulse
);

  // Position of the current tick, numbered from 1 after each retrace.
  assign pos = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= retrace;
      if (tick) cnt <= retrace ? '0 : pos;
    end
  end

endmodule

// File: rtl/vc_window.sv
module vc_window
  import vcount_pkg::*;
#(
  parameter int unsigned HL_W    = 10,
  parameter int unsigned SRCH_LO = 488,
  parameter int unsigned SRCH_HI = 722,
  parameter int unsigned N50     = 625,
  parameter int unsigned N60     = 525,
  parameter int unsigned NW      = 3
) (
  input  logic            tick,
  input  logic            sync,
  input  logic [HL_W-1:0] pos,
  input  vc_mode_e        mode,
  input  logic            std60,
  output logic            retrace,
  output logic            hit,
  output logic            miss,
  output logic            match,
  output logic            cand60
);

  int unsigned p;
  int unsigned nom;
  logic        sync_t;
  logic        s_in;

  always_comb begin
    p       = {{(32-HL_W){1'b0}}, pos};
    nom     = field_len(std60, N50, N60);
    sync_t  = tick & sync;
    s_in    = 1'b0;
    retrace = 1'b0;
    hit     = 1'b0;
    miss    = 1'b0;
    match   = 1'b0;
    cand60  = 1'b0;
    unique case (mode)
      VC_SEARCH: begin
        s_in    = sync_t && (p >= SRCH_LO) && (p <= SRCH_HI);
        retrace = tick && (s_in || (p >= SRCH_HI));
        cand60  = in_band(p, N60, NW);
        hit     = s_in && (in_band(p, N50, NW) || cand60);
      end
      VC_NARROW: begin
        s_in    = sync_t && in_band(p, nom, NW);
        retrace = tick && (s_in || (p >= nom + NW));
        hit     = s_in;
        match   = s_in && (p == nom);
        miss    = tick && !s_in && (p >= nom + NW);
      end
      VC_NORM: begin
        match   = sync_t && (p == nom);
        retrace = tick && (p >= nom);
        hit     = match;
        miss    = retrace && !match;
      end
      default: retrace = tick && (p >= SRCH_HI);
    endcase
  end

endmodule

// File: rtl/vc_tracker.sv
module vc_tracker
  import vcount_pkg::*;
#(
  parameter int unsigned SRCH_HITS   = 16,
  parameter int unsigned NORM_HITS   = 15,
  parameter int unsigned NARROW_MISS = 6,
  parameter int unsigned NORM_MISS   = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     force_search,
  input  logic     force_60,
  input  logic     retrace,
  input  logic     hit,
  input  logic     miss,
  input  logic     match,
  input  logic     cand60,
  output vc_mode_e mode,
  output logic     std60
);

  localparam int unsigned HW = $clog2(SRCH_HITS + 1);
  localparam int unsigned CW = $clog2(NORM_HITS + 1);
  localparam int unsigned MW = $clog2(NARROW_MISS + 1);

  logic [HW-1:0] hit_cnt;
  logic [CW-1:0] norm_cnt;
  logic [MW-1:0] miss_cnt;
  logic          demoted;
  logic [MW-1:0] miss_last;

  // A streak ends one short of the count that changes the mode.
  assign miss_last = demoted ? MW'(NORM_MISS - 1) : MW'(NARROW_MISS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= VC_SEARCH;
      std60    <= 1'b0;
      hit_cnt  <= '0;
      norm_cnt <= '0;
      miss_cnt <= '0;
      demoted  <= 1'b0;
    end else if (force_search || force_60) begin
      mode     <= force_search ? VC_SEARCH : VC_NORM;
      if (!force_search) std60 <= 1'b1;
      hit_cnt  <= '0;
      norm_cnt <= '0;
      miss_cnt <= '0;
      demoted  <= 1'b0;
    end else if (retrace) begin
      unique case (mode)
        VC_SEARCH: begin
          if (!hit) begin
            hit_cnt <= '0;
          end else begin
            std60 <= cand60;
            if (hit_cnt != '0 && cand60 != std60) begin
              hit_cnt <= HW'(1);
            end else if (hit_cnt == HW'(SRCH_HITS - 1)) begin
              mode    <= VC_NARROW;
              hit_cnt <= '0;
            end else begin
              hit_cnt <= hit_cnt + 1'b1;
            end
          end
        end
        VC_NARROW: begin
          if (hit) begin
            miss_cnt <= '0;
            demoted  <= 1'b0;
            if (!match) begin
              norm_cnt <= '0;
            end else if (norm_cnt == CW'(NORM_HITS - 1)) begin
              mode     <= VC_NORM;
              norm_cnt <= '0;
            end else begin
              norm_cnt <= norm_cnt + 1'b1;
            end
          end else if (miss) begin
            norm_cnt <= '0;
            if (miss_cnt == miss_last) begin
              mode     <= VC_SEARCH;
              miss_cnt <= '0;
              demoted  <= 1'b0;
            end else begin
              miss_cnt <= miss_cnt + 1'b1;
            end
          end
        end
        VC_NORM: begin
          if (hit) begin
            miss_cnt <= '0;
          end else if (miss) begin
            if (miss_cnt == MW'(NORM_MISS - 1)) begin
              mode     <= VC_NARROW;
              miss_cnt <= '0;
              demoted  <= 1'b1;
            end else begin
              miss_cnt <= miss_cnt + 1'b1;
            end
          end
        end
        default: mode <= VC_SEARCH;
      endcase
    end
  end

endmodule

// File: rtl/vcount_div.sv
module vcount_div
  import vcount_pkg::*;
#(
  parameter int unsigned SRCH_LO     = 488,
  parameter int unsigned SRCH_HI     = 722,
  parameter int unsigned N50         = 625,
  parameter int unsigned N60         = 525,
  parameter int unsigned NW          = 3,
  parameter int unsigned SRCH_HITS   = 16,
  parameter int unsigned NORM_HITS   = 15,
  parameter int unsigned NARROW_MISS = 6,
  parameter int unsigned NORM_MISS   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hl_tick,
  input  logic       vsync_in,
  input  logic       force_search,
  input  logic       force_60,
  output logic       vpulse,
  output logic [1:0] mode,
  output logic       is_60
);

  localparam int unsigned HL_W = $clog2(SRCH_HI + 1);

  // Named internal events, observed by the bound checker.
  logic [HL_W-1:0] hl_cnt;
  logic [HL_W-1:0] hl_pos;
  logic            retrace;
  logic            w_hit, w_miss, w_match, w_cand60;
  vc_mode_e        mode_q;
  logic            std60_q;

  vc_halfline_ctr #(.HL_W(HL_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (hl_tick),
    .retrace (retrace),
    .cnt     (hl_cnt),
    .pos     (hl_pos),
    .pulse   (vpulse)
  );

  vc_window #(
    .HL_W(HL_W), .SRCH_LO(SRCH_LO), .SRCH_HI(SRCH_HI),
    .N50(N50), .N60(N60), .NW(NW)
  ) u_win (
    .tick    (hl_tick),
    .sync    (vsync_in),
    .pos     (hl_pos),
    .mode    (mode_q),
    .std60   (std60_q),
    .retrace (retrace),
    .hit     (w_hit),
    .miss    (w_miss),
    .match   (w_match),
    .cand60  (w_cand60)
  );

  vc_tracker #(
    .SRCH_HITS(SRCH_HITS), .NORM_HITS(NORM_HITS),
    .NARROW_MISS(NARROW_MISS), .NORM_MISS(NORM_MISS)
  ) u_trk (
    .clk          (clk),
    .rst_n        (rst_n),
    .force_search (force_search),
    .force_60     (force_60),
    .retrace      (retrace),
    .hit          (w_hit),
    .miss         (w_miss),
    .match        (w_match),
    .cand60       (w_cand60),
    .mode         (mode_q),
    .std60        (std60_q)
  );

  assign mode  = mode_q;
  assign is_60 = std60_q;

endmodule

// File: rtl/vcount_div_chk.sv
module vcount_div_chk #(
  parameter int unsigned SRCH_HI = 722,
  parameter int unsigned HL_W    = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hl_tick,
  input logic            force_search,
  input logic            force_60,
  input logic            vpulse,
  input logic [1:0]      mode,
  input logic            is_60,
  input logic [HL_W-1:0] hl_cnt
);

  a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);

  a_r2_pulse_follows_tick: assert property (@(posedge clk) disable iff (!rst_n)
    vpulse |-> $past(hl_tick));

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vpulse |=> !vpulse);

  a_r12_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    {{(32-HL_W){1'b0}}, hl_cnt} < SRCH_HI);

  a_r10_force_search: assert property (@(posedge clk) disable iff (!rst_n)
    force_search |=> mode == 2'd0);

  a_r11_force_60: assert property (@(posedge clk) disable iff (!rst_n)
    (force_60 && !force_search) |=> (mode == 2'd2 && is_60));

  a_r8_norm_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !force_search) |=> mode != 2'd0);

  a_r3_search_steps_up: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && !force_60) |=> mode != 2'd2);

endmodule

bind vcount_div vcount_div_chk #(.SRCH_HI(SRCH_HI), .HL_W(HL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hl_tick      (hl_tick),
  .force_search (force_search),
  .force_60     (force_60),
  .vpulse       (vpulse),
  .mode         (mode),
  .is_60        (is_60),
  .hl_cnt       (hl_cnt)
);

// File: tb/sim_vcount_div.sv
module sim_vcount_div;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hl_tick = 1'b0;
  logic       vsync_in = 1'b0;
  logic       force_search = 1'b0;
  logic       force_60 = 1'b0;
  logic       vpulse;
  logic [1:0] mode;
  logic       is_60;

  int nchk = 0;
  int nfail = 0;

  always #2 clk = ~clk;  // 250 MHz

  vcount_div u0 (
    .clk(clk), .rst_n(rst_n), .hl_tick(hl_tick), .vsync_in(vsync_in),
    .force_search(force_search), .force_60(force_60),
    .vpulse(vpulse), .mode(mode), .is_60(is_60)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One half-line: tick (with optional sync) for a cycle, then a cycle
  // without tick carrying an optional stray sync.
  task automatic tick1(input bit vs, input bit stray, output bit pulse);
    @(negedge clk);
    hl_tick  = 1'b1;
    vsync_in = vs;
    @(negedge clk);
    hl_tick  = 1'b0;
    vsync_in = stray;
    pulse    = vpulse;
  endtask

  // Ticks until a retrace pulse; returns the field length in half-lines.
  task automatic run_field(input int sync_at, input int stray_at, output int len);
    bit p;
    len = -1;
    for (int k = 1; k <= 1500; k++) begin
      tick1(k == sync_at, k == stray_at, p);
      if (p) begin
        len = k;
        break;
      end
    end
    @(negedge clk);
    vsync_in = 1'b0;
  endtask

  task automatic fields(input int n, input int sync_at, input int exp_len,
                        input string req);
    int len;
    for (int i = 0; i < n; i++) begin
      run_field(sync_at, 0, len);
      chk(req, len, exp_len);
    end
  endtask

  task automatic t_reset;
    chk("R1 mode", int'(mode), 0);
    chk("R1 is_60", int'(is_60), 0);
    chk("R1 vpulse", int'(vpulse), 0);
  endtask

  task automatic t_search_freerun;
    int len;
    run_field(400, 600, len);   // early sync and off-tick sync both ignored
    chk("R2 stray syncs ignored", len, 722);
    run_field(0, 0, len);
    chk("R2 free run at window end", len, 722);
    run_field(600, 0, len);     // non-standard field accepted
    chk("R2 sync inside search window", len, 600);
    chk("R2 mode", int'(mode), 0);
  endtask

  task automatic t_lock50;
    fields(15, 625, 625, "R3 search field");
    chk("R3 still search after 15", int'(mode), 0);
    fields(1, 625, 625, "R3 search field");
    chk("R3 narrow after 16", int'(mode), 1);
    chk("R3 standard 50", int'(is_60), 0);
  endtask

  task automatic t_narrow_to_norm;
    fields(1, 0, 628, "R4 flywheel at window end");
    fields(1, 500, 628, "R4 early sync ignored");
    fields(1, 624, 624, "R4 in-window sync");
    fields(10, 625, 625, "R6 norm streak");
    fields(1, 623, 623, "R6 off-nominal hit");
    fields(14, 625, 625, "R6 norm streak");
    chk("R6 streak restarted", int'(mode), 1);
    fields(1, 625, 625, "R6 norm streak");
    chk("R6 norm after 15", int'(mode), 2);
  endtask

  task automatic t_norm;
    fields(1, 0, 625, "R7 missing sync");
    fields(1, 620, 625, "R7 early sync");
    fields(1, 625, 625, "R8 hit clears misses");
    fields(2, 0, 625, "R7 missing sync");
    chk("R8 still norm after 2", int'(mode), 2);
    fields(1, 0, 625, "R7 missing sync");
    chk("R8 narrow after 3", int'(mode), 1);
  endtask

  task automatic t_demoted;
    fields(2, 0, 628, "R9 flywheel");
    chk("R9 still narrow after 2", int'(mode), 1);
    fields(1, 0, 628, "R9 flywheel");
    chk("R9 search after 3", int'(mode), 0);
  endtask

  task automatic t_lock60;
    fields(16, 525, 525, "R3 search 60");
    chk("R3 narrow 60", int'(mode), 1);
    chk("R3 standard 60", int'(is_60), 1);
    fields(5, 0, 528, "R5 flywheel 60");
    fields(1, 526, 526, "R5 hit clears");
    fields(5, 0, 528, "R5 flywheel 60");
    chk("R5 still narrow after 5", int'(mode), 1);
    fields(1, 0, 528, "R5 flywheel 60");
    chk("R5 search after 6", int'(mode), 0);
  endtask

  task automatic t_forces;
    int len;
    @(negedge clk);
    force_60 = 1'b1;
    @(negedge clk);
    chk("R11 forced norm", int'(mode), 2);
    chk("R11 forced 60", int'(is_60), 1);
    fields(2, 0, 525, "R11 forced length");
    chk("R11 misses ignored", int'(mode), 2);
    force_search = 1'b1;
    @(negedge clk);
    chk("R10 search wins", int'(mode), 0);
    run_field(625, 0, len);
    chk("R10 streak held clear", int'(mode), 0);
    chk("R10 search retrace", len, 625);
    force_search = 1'b0;
    force_60     = 1'b0;
    @(negedge clk);
    chk("R10 stays search", int'(mode), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_search_freerun();
    t_lock50();
    t_narrow_to_norm();
    t_norm();
    t_demoted();
    t_lock60();
    t_forces();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule